// File: doc/BRIEF.md
# Home Directory for Four-Cache Coherence

This block is the home node of a directory-based coherence scheme for a small set of memory lines shared by four caches. Caches do not snoop a bus. They send point-to-point requests to this block. For every line the block holds a state (uncached, shared or modified), a 4-bit vector of the caches that hold the line, and the line's memory copy.

Read requests for lines that no cache holds dirty are served directly from the memory copy. Write and upgrade requests cause invalidations to be sent to the other holders. The block counts their acknowledgements before it grants ownership. When a line is dirty in another cache, the block forwards the request to that owner and receives the owner's data. It then passes the data on to the requester. When the request was a read, it also writes the data back to memory, and both caches end up as sharers.

Only one transaction is in flight at a time. While the block waits for acknowledgements or owner data, it holds the request channel not ready.

Top module: `dir_home`

## Requirements
- R1: After reset every line is uncached with an empty holder vector, and its memory copy is (line*29+3) mod 2^DW. No message or writeback is valid, and `req_ready` is high.
- R2: A read (req_kind 0) of an uncached or shared line gets a shared grant (msg_kind 0) one cycle after acceptance. The grant goes to the requester and carries the memory copy. The requester joins the holder set.
- R3: A write (1) or upgrade (2) of an uncached line gets a modified grant (msg_kind 1) that carries the memory copy. The line becomes modified, with the requester as sole owner.
- R4: A write or upgrade of a shared line held by other caches sends one invalidation (msg_kind 3) per cycle to each of those caches, in ascending cache index. The requester never receives one.
- R5: After the invalidations are sent, the requester receives a permission-only grant (msg_kind 2) if it made an upgrade and was a holder. Otherwise it receives a modified grant carrying the memory copy. In both cases the line becomes modified with the requester as owner.
- R6: A write or upgrade of a line modified in another cache sends a write forward (msg_kind 5) to the owner. When the owner's data arrives (ack_kind 1), the requester gets a modified grant carrying that data, and no writeback occurs.
- R7: A read of a line modified in another cache sends a read forward (msg_kind 4) to the owner. When the owner's data arrives, the data is written back to memory in the same cycle that a shared grant with that data goes to the requester. The old owner and the requester become the holders, and later reads return the written-back data.
- R8: While invalidation acknowledgements or owner data are pending, `req_ready` is low. The grant is issued only after all acknowledgements (ack_kind 0) have arrived.
- R9: A read, write or upgrade from the cache that already owns a modified line is answered with a permission-only grant, and the entry is left unchanged.
- R10: An acknowledgement or data return is ignored if it names another line, or if it is data from a cache other than the owner.
- R11: An upgrade from the only holder of a shared line is granted permission-only at once, with no invalidation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_kind | input | 2 | 0 read, 1 write, 2 upgrade |
| req_src | input | CW | Requesting cache |
| req_line | input | LW | Line index |
| msg_valid | output | 1 | Outgoing message valid |
| msg_kind | output | 3 | 0 shared grant, 1 modified grant, 2 permission, 3 invalidate, 4 read forward, 5 write forward |
| msg_dst | output | CW | Destination cache |
| msg_line | output | LW | Line index of message |
| msg_data | output | DW | Line data for grants |
| ack_valid | input | 1 | Cache reply valid |
| ack_kind | input | 1 | 0 invalidation ack, 1 owner data |
| ack_src | input | CW | Replying cache |
| ack_line | input | LW | Line of the reply |
| ack_data | input | DW | Owner data |
| mem_wr_valid | output | 1 | Memory writeback valid |
| mem_wr_line | output | LW | Writeback line |
| mem_wr_data | output | DW | Writeback data |

## Verification
On every cycle, the assertions check three things. Invalidations go only to current holders other than the requester. Forwards go only to the sole owner of a modified line. A modified grant leaves exactly its destination as owner. Beyond these, a writeback always coincides with a shared grant of the same line and data, and no grant leaves while acknowledgements are still counted as outstanding.

Only the bench scenarios can show the rest. These are the ordering of whole message sequences, the data passed from an old owner to a new one, the return of written-back data on a later read, and the rejection of stray replies. The bench shows the last of these by injecting stray replies and observing that the grant waits for the real one.

// File: rtl/dir_home.sv
module dir_home #(
  parameter int NCACHE = 4,
  parameter int NLINES = 8,
  parameter int DW     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [1:0]                req_kind,
  input  logic [$clog2(NCACHE)-1:0] req_src,
  input  logic [$clog2(NLINES)-1:0] req_line,
  output logic                      msg_valid,
  output logic [2:0]                msg_kind,
  output logic [$clog2(NCACHE)-1:0] msg_dst,
  output logic [$clog2(NLINES)-1:0] msg_line,
  output logic [DW-1:0]             msg_data,
  input  logic                      ack_valid,
  input  logic                      ack_kind,
  input  logic [$clog2(NCACHE)-1:0] ack_src,
  input  logic [$clog2(NLINES)-1:0] ack_line,
  input  logic [DW-1:0]             ack_data,
  output logic                      mem_wr_valid,
  output logic [$clog2(NLINES)-1:0] mem_wr_line,
  output logic [DW-1:0]             mem_wr_data
);
  localparam int CW = $clog2(NCACHE);
  localparam int LW = $clog2(NLINES);

  localparam logic [1:0] ST_U = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [1:0] RQ_RD = 2'd0, RQ_UP = 2'd2;
  localparam logic [2:0] M_GS = 3'd0, M_GM = 3'd1, M_PERM = 3'd2,
                         M_INV = 3'd3, M_FRD = 3'd4, M_FWR = 3'd5;

  typedef enum logic [1:0] {F_IDLE, F_INV, F_ACK, F_DATA} fsm_t;

  logic [1:0]        st_q  [NLINES];
  logic [NCACHE-1:0] vec_q [NLINES];
  logic [DW-1:0]     mem_q [NLINES];

  fsm_t              fsm;
  logic [LW-1:0]     t_line;
  logic [CW-1:0]     t_src, t_own;
  logic [1:0]        t_kind;
  logic [NCACHE-1:0] t_pend;
  logic [CW:0]       t_cnt;

  function automatic logic [CW-1:0] low_idx(input logic [NCACHE-1:0] v);
    low_idx = '0;
    for (int i = NCACHE - 1; i >= 0; i--)
      if (v[i]) low_idx = CW'(i);
  endfunction

  localparam logic [NCACHE-1:0] ONE = NCACHE'(1);

  logic [1:0]        e_st;
  logic [NCACHE-1:0] e_vec, r_bit, others, t_bit, t_vec, pend_rest;
  logic              accept, self_own, ack_hit, data_hit, keep_perm;

  assign req_ready = (fsm == F_IDLE);
  assign accept    = req_valid && req_ready;
  assign e_st      = st_q[req_line];
  assign e_vec     = vec_q[req_line];
  assign r_bit     = ONE << req_src;
  assign others    = e_vec & ~r_bit;
  assign self_own  = (e_st == ST_M) && (e_vec == r_bit);
  assign t_bit     = ONE << t_src;
  assign t_vec     = vec_q[t_line];
  assign keep_perm = (t_kind == RQ_UP) && t_vec[t_src];
  assign pend_rest = t_pend & (t_pend - ONE);
  assign ack_hit   = ack_valid && !ack_kind && (ack_line == t_line) &&
                     (fsm == F_INV || fsm == F_ACK) && (t_cnt != '0);
  assign data_hit  = ack_valid && ack_kind && (ack_line == t_line) &&
                     (ack_src == t_own) && (fsm == F_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm          <= F_IDLE;
      t_line       <= '0;
      t_src        <= '0;
      t_own        <= '0;
      t_kind       <= '0;
      t_pend       <= '0;
      t_cnt        <= '0;
      msg_valid    <= 1'b0;
      msg_kind     <= '0;
      msg_dst      <= '0;
      msg_line     <= '0;
      msg_data     <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_line  <= '0;
      mem_wr_data  <= '0;
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]  <= ST_U;
        vec_q[i] <= '0;
        mem_q[i] <= DW'(i * 29 + 3);
      end
    end else begin
      msg_valid    <= 1'b0;
      mem_wr_valid <= 1'b0;
      if (ack_hit) t_cnt <= t_cnt - 1'b1;
      case (fsm)
        F_IDLE: if (accept) begin
          t_line <= req_line;
          t_src  <= req_src;
          t_kind <= req_kind;
          if (self_own) begin
            msg_valid <= 1'b1;
            msg_kind  <= M_PERM;
            msg_dst   <= req_src;
            msg_line  <= req_line;
            msg_data  <= '0;
          end else if (e_st == ST_M) begin
            t_own     <= low_idx(e_vec);
            msg_valid <= 1'b1;
            msg_kind  <= (req_kind == RQ_RD) ? M_FRD : M_FWR;
            msg_dst   <= low_idx(e_vec);
            msg_line  <= req_line;
            msg_data  <= '0;
            fsm       <= F_DATA;
          end else if (req_kind == RQ_RD) begin
            msg_valid       <= 1'b1;
            msg_kind        <= M_GS;
            msg_dst         <= req_src;
            msg_line        <= req_line;
            msg_data        <= mem_q[req_line];
            st_q[req_line]  <= ST_S;
            vec_q[req_line] <= e_vec | r_bit;
          end else if (others == '0) begin
            msg_valid       <= 1'b1;
            msg_kind        <= (req_kind == RQ_UP && e_vec[req_src]) ? M_PERM : M_GM;
            msg_dst         <= req_src;
            msg_line        <= req_line;
            msg_data        <= mem_q[req_line];
            st_q[req_line]  <= ST_M;
            vec_q[req_line] <= r_bit;
          end else begin
            t_pend <= others;
            t_cnt  <= (CW+1)'($countones(others));
            fsm    <= F_INV;
          end
        end
        F_INV: begin
          msg_valid <= 1'b1;
          msg_kind  <= M_INV;
          msg_dst   <= low_idx(t_pend);
          msg_line  <= t_line;
          msg_data  <= '0;
          t_pend    <= pend_rest;
          if (pend_rest == '0) fsm <= F_ACK;
        end
        F_ACK: if (t_cnt == '0) begin
          msg_valid     <= 1'b1;
          msg_kind      <= keep_perm ? M_PERM : M_GM;
          msg_dst       <= t_src;
          msg_line      <= t_line;
          msg_data      <= mem_q[t_line];
          st_q[t_line]  <= ST_M;
          vec_q[t_line] <= t_bit;
          fsm           <= F_IDLE;
        end
        F_DATA: if (data_hit) begin
          msg_valid <= 1'b1;
          msg_dst   <= t_src;
          msg_line  <= t_line;
          msg_data  <= ack_data;
          if (t_kind == RQ_RD) begin
            msg_kind      <= M_GS;
            mem_q[t_line] <= ack_data;
            mem_wr_valid  <= 1'b1;
            mem_wr_line   <= t_line;
            mem_wr_data   <= ack_data;
            st_q[t_line]  <= ST_S;
            vec_q[t_line] <= t_bit | (ONE << t_own);
          end else begin
            msg_kind      <= M_GM;
            st_q[t_line]  <= ST_M;
            vec_q[t_line] <= t_bit;
          end
          fsm <= F_IDLE;
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  p_inv_to_holder_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == M_INV |-> vec_q[msg_line][msg_dst] && msg_dst != t_src);

  p_fwd_to_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && (msg_kind == M_FRD || msg_kind == M_FWR) |->
      st_q[msg_line] == ST_M && vec_q[msg_line] == (ONE << msg_dst));

  p_owner_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == M_GM |->
      st_q[msg_line] == ST_M && vec_q[msg_line] == (ONE << msg_dst));

  p_wb_with_share_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> msg_valid && msg_kind == M_GS &&
      msg_line == mem_wr_line && msg_data == mem_wr_data);

  p_grant_after_acks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fsm == F_ACK && t_cnt != '0 |=>
      !(msg_valid && (msg_kind == M_PERM || msg_kind == M_GM)));
endmodule

// File: tb/test_dir_home.sv
module test_dir_home;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = '0;
  logic [1:0] req_src = '0;
  logic [2:0] req_line = '0;
  logic       msg_valid;
  logic [2:0] msg_kind;
  logic [1:0] msg_dst;
  logic [2:0] msg_line;
  logic [7:0] msg_data;
  logic       ack_valid = 1'b0;
  logic       ack_kind = 1'b0;
  logic [1:0] ack_src = '0;
  logic [2:0] ack_line = '0;
  logic [7:0] ack_data = '0;
  logic       mem_wr_valid;
  logic [2:0] mem_wr_line;
  logic [7:0] mem_wr_data;

  always #(CLK_P/2) clk = ~clk;

  dir_home i_dir_home (
    .clk, .rst_n, .req_valid, .req_ready, .req_kind, .req_src, .req_line,
    .msg_valid, .msg_kind, .msg_dst, .msg_line, .msg_data,
    .ack_valid, .ack_kind, .ack_src, .ack_line, .ack_data,
    .mem_wr_valid, .mem_wr_line, .mem_wr_data);

  typedef struct {
    logic [2:0] k; logic [1:0] d; logic [2:0] l; logic [7:0] data;
    bit after_inv; string rq;
  } exp_t;
  typedef struct {
    logic kind; logic [1:0] src; logic [2:0] line; logic [7:0] data;
    int gap; bit real_ack;
  } resp_t;

  exp_t        exp_q[$];
  logic [10:0] wb_q[$];
  resp_t       resp_q[$];
  int vectors = 0, errors = 0, acks_owed = 0;
  bit hold_fwd = 1'b0;

  logic [1:0] m_st [8];
  logic [3:0] m_vec[8];
  logic [7:0] m_mem[8];

  function automatic logic [7:0] own_d(input int l, input int c);
    return 8'h80 | 8'(l * 4 + c);
  endfunction

  task automatic chk(input string rq, input string what, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  task automatic push_exp(input logic [2:0] k, input int d, input int l,
                          input logic [7:0] data, input bit ai, input string rq);
    exp_t e;
    e.k = k; e.d = 2'(d); e.l = 3'(l); e.data = data; e.after_inv = ai; e.rq = rq;
    exp_q.push_back(e);
  endtask

  task automatic push_resp(input logic kind, input int src, input int line,
                           input logic [7:0] data, input int gap, input bit ra);
    resp_t r;
    r.kind = kind; r.src = 2'(src); r.line = 3'(line); r.data = data;
    r.gap = gap; r.real_ack = ra;
    resp_q.push_back(r);
  endtask

  // expected outcome of a request, derived from the requirements
  task automatic model(input int kind, input int src, input int l, input string rq);
    logic [3:0] bit_r, oth;
    int owner;
    bit_r = 4'(1 << src);
    oth   = m_vec[l] & ~bit_r;
    owner = 0;
    for (int c = 3; c >= 0; c--) if (m_vec[l][c]) owner = c;
    if (m_st[l] == 2 && m_vec[l] == bit_r) begin
      push_exp(3'd2, src, l, 8'h00, 1'b0, rq);
    end else if (m_st[l] == 2) begin
      push_exp(kind == 0 ? 3'd4 : 3'd5, owner, l, 8'h00, 1'b0, rq);
      if (kind == 0) begin
        push_exp(3'd0, src, l, own_d(l, owner), 1'b0, rq);
        wb_q.push_back({3'(l), own_d(l, owner)});
        m_mem[l] = own_d(l, owner);
        m_st[l]  = 1;
        m_vec[l] = bit_r | 4'(1 << owner);
      end else begin
        push_exp(3'd1, src, l, own_d(l, owner), 1'b0, rq);
        m_vec[l] = bit_r;
      end
    end else if (kind == 0) begin
      push_exp(3'd0, src, l, m_mem[l], 1'b0, rq);
      m_st[l]  = 1;
      m_vec[l] = m_vec[l] | bit_r;
    end else begin
      for (int c = 0; c < 4; c++)
        if (oth[c]) push_exp(3'd3, c, l, 8'h00, 1'b0, rq);
      push_exp((kind == 2 && m_vec[l][src]) ? 3'd2 : 3'd1, src, l, m_mem[l],
               oth != 0, rq);
      m_st[l]  = 2;
      m_vec[l] = bit_r;
    end
  endtask

  task automatic issue(input int kind, input int src, input int l, input string rq);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    model(kind, src, l, rq);
    req_valid = 1'b1;
    req_kind  = 2'(kind);
    req_src   = 2'(src);
    req_line  = 3'(l);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain;
    int n;
    n = 0;
    while ((exp_q.size() != 0 || resp_q.size() != 0 || !req_ready) && n < 500) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  // monitor: scoreboard compare, and cache-side replies
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && msg_valid) begin
        if (exp_q.size() == 0) begin
          chk("R4", "unexpected message kind", int'(msg_kind), 7);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.rq, "kind/dst/line", int'({msg_kind, msg_dst, msg_line}),
              int'({e.k, e.d, e.l}));
          if (e.k <= 3'd1) chk(e.rq, "grant data", int'(msg_data), int'(e.data));
          if (e.after_inv) chk("R8", "acks outstanding at grant", acks_owed, 0);
        end
        if (msg_kind == 3'd3) begin
          acks_owed++;
          push_resp(1'b0, msg_dst, msg_line, 8'h00, 1, 1'b1);
        end
        if ((msg_kind == 3'd4 || msg_kind == 3'd5) && !hold_fwd)
          push_resp(1'b1, msg_dst, msg_line, own_d(msg_line, msg_dst), 1, 1'b0);
      end
      if (rst_n && mem_wr_valid) begin
        if (wb_q.size() == 0) begin
          chk("R6", "unexpected writeback line", int'(mem_wr_line), 8);
        end else begin
          logic [10:0] w;
          w = wb_q.pop_front();
          chk("R7", "writeback line/data", int'({mem_wr_line, mem_wr_data}), int'(w));
        end
      end
    end
  end

  // responder: drives the reply channel one item at a time
  initial begin
    forever begin
      @(negedge clk);
      ack_valid = 1'b0;
      if (resp_q.size() != 0) begin
        resp_t r;
        r = resp_q.pop_front();
        repeat (r.gap) @(negedge clk);
        ack_kind  = r.kind;
        ack_src   = r.src;
        ack_line  = r.line;
        ack_data  = r.data;
        ack_valid = 1'b1;
        if (r.real_ack) acks_owed--;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < 8; l++) begin
      m_st[l] = 0; m_vec[l] = 0; m_mem[l] = 8'(l * 29 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_ready after reset", int'(req_ready), 1);
    chk("R1", "msg_valid after reset", int'(msg_valid), 0);
    chk("R1", "mem_wr_valid after reset", int'(mem_wr_valid), 0);

    // R2: reads from three caches build a holder set
    issue(0, 0, 1, "R2");
    issue(0, 1, 1, "R2");
    issue(0, 2, 1, "R2");
    drain();
    // R4/R5: upgrade by holder 1 invalidates 0 and 2
    issue(2, 1, 1, "R5");
    chk("R8", "req_ready while invalidating", int'(req_ready), 0);
    drain();
    // R7: read of a modified line, then reread from memory
    issue(0, 3, 1, "R7");
    chk("R8", "req_ready while awaiting owner", int'(req_ready), 0);
    drain();
    issue(0, 0, 1, "R7");
    drain();
    // R4/R5: write by a non-holder of a shared line
    issue(1, 2, 1, "R4");
    drain();
    // R6: write of a line modified elsewhere
    issue(1, 0, 1, "R6");
    drain();
    // R3: write and upgrade of uncached lines
    issue(1, 3, 2, "R3");
    issue(2, 1, 3, "R3");
    drain();
    // R9: requests from the current owner
    issue(0, 3, 2, "R9");
    issue(1, 3, 2, "R9");
    issue(2, 3, 2, "R9");
    drain();
    // R11: upgrade by the only holder
    issue(0, 0, 4, "R11");
    issue(2, 0, 4, "R11");
    drain();
    // R10: stray owner data before the real one
    hold_fwd = 1'b1;
    issue(0, 1, 2, "R10");
    push_resp(1'b1, 3, 3, 8'h55, 0, 1'b0);
    push_resp(1'b1, 0, 2, 8'h66, 0, 1'b0);
    push_resp(1'b1, 3, 2, own_d(2, 3), 2, 1'b0);
    hold_fwd = 1'b0;
    drain();
    // R10: stray acknowledgement for another line during invalidation
    issue(0, 0, 5, "R10");
    issue(0, 1, 5, "R10");
    issue(0, 2, 5, "R10");
    drain();
    issue(2, 0, 5, "R10");
    push_resp(1'b0, 1, 6, 8'h00, 0, 1'b0);
    drain();
    chk("R10", "pending expected messages", exp_q.size(), 0);
    chk("R7", "pending writebacks", wb_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule